// File: doc/BRIEF.md
# Programming Frame Receiver and Checker

This block sits behind a UART receiver on a flash-programming link and turns the incoming byte stream into checked packets. Two packet kinds are recognised. A command packet carries a command code and optional parameter bytes. A data packet carries payload bytes only. The block walks each packet byte by byte. It checks the length field and the subtract-from-zero checksum, and it checks that the closing byte is legal for the packet kind. It then reports one result per packet.

Downstream logic receives the command code with its own strobe and every parameter or data byte with a payload strobe. A one-cycle completion pulse carries a two-bit status and a flag. The flag shows that a data packet was closed with the "more blocks follow" code. A programmable silence limit discards a packet that stops arriving partway through, so the receiver is not left stuck in the middle of a frame.

Top module: `prog_frame_rx`

## Requirements
- R1: A packet opened by byte 0x01 is a command packet. The next bytes are the length, the command code, the parameters, the checksum and the closing byte. The command code appears on `cmdNum` with `cmdValid` high for one cycle, in the cycle after the code byte is accepted. Each parameter byte then appears on `payByte` with `payValid`. `frameIsData` reads 0 for such a packet.
- R2: A packet opened by byte 0x02 is a data packet. The next bytes are the length, the data bytes, the checksum and the closing byte. Each data byte appears on `payByte` with `payValid` high for one cycle, in the cycle after the byte is accepted. `frameIsData` reads 1 for such a packet.
- R3: In a command packet the length byte counts the command code plus the parameters. In a data packet it counts only the data bytes. A length byte of 0x00 stands for 256.
- R4: The checksum byte must equal 0x00 minus the sum of the covered bytes, modulo 256. The covered bytes are the length byte, the command code and the parameters, or the length byte and the data bytes. A mismatch gives status 1.
- R5: A command packet must close with 0x03. A data packet may close with 0x03 or with 0x17. Any other closing byte gives status 2, and this status takes priority over a checksum mismatch.
- R6: In the cycle after the closing byte is accepted, `doneValid` pulses for one cycle. A packet that passes every check reports status 0.
- R7: `moreFollows` is high only together with `doneValid`. It is high exactly when a data packet closed with 0x17.
- R8: While no packet is open, any byte other than 0x01 or 0x02 is dropped and causes no output.
- R9: Inside an open packet, a silence of `timeoutCycles` clock cycles after the last accepted byte ends the packet. `doneValid` then pulses with status 3 exactly `timeoutCycles` cycles after the edge that took that byte, and the block returns to idle. A limit of 0 disables the timeout.
- R10: `doneValid` never stays high for two cycles in a row and never coincides with `payValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | A received byte is present this cycle |
| rxByte | input | 8 | Received byte |
| timeoutCycles | input | TO_W | Silence limit in cycles; 0 disables |
| frameIsData | output | 1 | Kind of the current or last packet (1 = data) |
| cmdValid | output | 1 | Command code strobe |
| cmdNum | output | 8 | Command code |
| payValid | output | 1 | Parameter or data byte strobe |
| payByte | output | 8 | Parameter or data byte |
| doneValid | output | 1 | End-of-packet result pulse |
| doneStatus | output | 2 | 0 ok, 1 checksum error, 2 framing error, 3 timeout |
| moreFollows | output | 1 | Data packet closed with 0x17 |

## Verification
The bench targets three corner cases:

- A length byte of zero, which must yield 256 data bytes. A design that took it literally would treat the checksum as data and report a framing fault.
- A wrong closing byte in the same packet as a bad checksum, which must report framing. A design with the wrong priority would report checksum.
- A truncated packet. The completion pulse is timed to the exact cycle, and a limit of zero followed by a later nonzero limit must still fire. A counter that only matches on equality would stall forever in that case.

Garbage bytes between packets and 0x17 used to close a command packet round out the cases.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

  localparam logic [7:0] HDR_CMD  = 8'h01;
  localparam logic [7:0] HDR_DATA = 8'h02;
  localparam logic [7:0] TRL_END  = 8'h03;
  localparam logic [7:0] TRL_MORE = 8'h17;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_SUM     = 2'd1,
    ST_FRAME   = 2'd2,
    ST_TIMEOUT = 2'd3
  } frameStatus_t;

  // strobes from control to datapath, one decision per cycle
  typedef struct packed {
    logic inFrame;
    logic startFrame;
    logic isDataHdr;
    logic loadLen;
    logic takeCom;
    logic takeBody;
    logic takeSum;
    logic finish;
    logic abort;
  } ctrlStrobe_t;

endpackage

// File: rtl/pfr_ctrl.sv
module pfr_ctrl
  import pfr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  input  logic        frameIsData,
  input  logic        cntIsOne,
  input  logic        timerExpired,
  output ctrlStrobe_t strobe
);

  typedef enum logic [2:0] {
    S_IDLE, S_LEN, S_COM, S_BODY, S_SUM, S_TRAIL
  } rxState_t;

  rxState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    strobe         = '0;
    nextState      = state;
    strobe.inFrame = (state != S_IDLE);
    if (state != S_IDLE && !rxValid && timerExpired) begin
      strobe.abort = 1'b1;
      nextState    = S_IDLE;
    end else if (rxValid) begin
      unique case (state)
        S_IDLE: begin
          if (rxByte == HDR_CMD || rxByte == HDR_DATA) begin
            strobe.startFrame = 1'b1;
            strobe.isDataHdr  = (rxByte == HDR_DATA);
            nextState         = S_LEN;
          end
        end
        S_LEN: begin
          strobe.loadLen = 1'b1;
          nextState      = frameIsData ? S_BODY : S_COM;
        end
        S_COM: begin
          strobe.takeCom = 1'b1;
          nextState      = cntIsOne ? S_SUM : S_BODY;
        end
        S_BODY: begin
          strobe.takeBody = 1'b1;
          nextState       = cntIsOne ? S_SUM : S_BODY;
        end
        S_SUM: begin
          strobe.takeSum = 1'b1;
          nextState      = S_TRAIL;
        end
        S_TRAIL: begin
          strobe.finish = 1'b1;
          nextState     = S_IDLE;
        end
        default: nextState = S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pfr_dpath.sv
module pfr_dpath
  import pfr_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rxValid,
  input  logic [7:0]      rxByte,
  input  logic [TO_W-1:0] timeoutCycles,
  input  ctrlStrobe_t     strobe,
  output logic            cntIsOne,
  output logic            timerExpired,
  output logic            frameIsData,
  output logic            cmdValid,
  output logic [7:0]      cmdNum,
  output logic            payValid,
  output logic [7:0]      payByte,
  output logic            doneValid,
  output frameStatus_t    doneStatus,
  output logic            moreFollows
);

  localparam int CNT_W = 9;  // holds 1..256

  logic [7:0]      sumAcc;
  logic [CNT_W-1:0] cnt;
  logic [TO_W-1:0] timer;
  logic            sumOk;
  logic            trailerOk;

  assign cntIsOne     = (cnt == CNT_W'(1));
  // >= so a limit lowered mid-frame still fires at once
  assign timerExpired = (timeoutCycles != '0) &&
                        (timer >= timeoutCycles - TO_W'(1));
  assign trailerOk    = (rxByte == TRL_END) ||
                        (frameIsData && rxByte == TRL_MORE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sumAcc      <= '0;
      cnt         <= '0;
      timer       <= '0;
      sumOk       <= 1'b0;
      frameIsData <= 1'b0;
      cmdValid    <= 1'b0;
      cmdNum      <= '0;
      payValid    <= 1'b0;
      payByte     <= '0;
      doneValid   <= 1'b0;
      doneStatus  <= ST_OK;
      moreFollows <= 1'b0;
    end else begin
      cmdValid    <= 1'b0;
      payValid    <= 1'b0;
      doneValid   <= 1'b0;
      moreFollows <= 1'b0;

      if (!strobe.inFrame || rxValid) timer <= '0;
      else if (!timerExpired)         timer <= timer + TO_W'(1);

      if (strobe.startFrame) frameIsData <= strobe.isDataHdr;

      if (strobe.loadLen) begin
        sumAcc <= 8'h00 - rxByte;
        cnt    <= (rxByte == 8'h00) ? CNT_W'(256) : {1'b0, rxByte};
      end

      if (strobe.takeCom || strobe.takeBody) begin
        sumAcc <= sumAcc - rxByte;
        cnt    <= cnt - CNT_W'(1);
      end

      if (strobe.takeCom) begin
        cmdNum   <= rxByte;
        cmdValid <= 1'b1;
      end

      if (strobe.takeBody) begin
        payByte  <= rxByte;
        payValid <= 1'b1;
      end

      if (strobe.takeSum) sumOk <= (rxByte == sumAcc);

      if (strobe.finish) begin
        doneValid   <= 1'b1;
        moreFollows <= frameIsData && (rxByte == TRL_MORE);
        if (!trailerOk)  doneStatus <= ST_FRAME;
        else if (!sumOk) doneStatus <= ST_SUM;
        else             doneStatus <= ST_OK;
      end

      if (strobe.abort) begin
        doneValid  <= 1'b1;
        doneStatus <= ST_TIMEOUT;
      end
    end
  end

endmodule

// File: rtl/prog_frame_rx.sv
module prog_frame_rx
  import pfr_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rxValid,
  input  logic [7:0]      rxByte,
  input  logic [TO_W-1:0] timeoutCycles,
  output logic            frameIsData,
  output logic            cmdValid,
  output logic [7:0]      cmdNum,
  output logic            payValid,
  output logic [7:0]      payByte,
  output logic            doneValid,
  output logic [1:0]      doneStatus,
  output logic            moreFollows
);

  ctrlStrobe_t  strobe;
  logic         cntIsOne;
  logic         timerExpired;
  frameStatus_t statusQ;

  pfr_ctrl ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rxValid      (rxValid),
    .rxByte       (rxByte),
    .frameIsData  (frameIsData),
    .cntIsOne     (cntIsOne),
    .timerExpired (timerExpired),
    .strobe       (strobe)
  );

  pfr_dpath #(.TO_W(TO_W)) dpath_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .rxValid       (rxValid),
    .rxByte        (rxByte),
    .timeoutCycles (timeoutCycles),
    .strobe        (strobe),
    .cntIsOne      (cntIsOne),
    .timerExpired  (timerExpired),
    .frameIsData   (frameIsData),
    .cmdValid      (cmdValid),
    .cmdNum        (cmdNum),
    .payValid      (payValid),
    .payByte       (payByte),
    .doneValid     (doneValid),
    .doneStatus    (statusQ),
    .moreFollows   (moreFollows)
  );

  assign doneStatus = statusQ;

endmodule

// File: rtl/pfr_checker.sv
module pfr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rxValid,
  input logic       frameIsData,
  input logic       cmdValid,
  input logic       payValid,
  input logic       doneValid,
  input logic [1:0] doneStatus,
  input logic       moreFollows
);

  // R1
  cmd_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid |-> (!frameIsData && $past(rxValid)));

  // R2
  pay_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    payValid |-> $past(rxValid));

  // R7
  more_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    moreFollows |-> (doneValid && frameIsData && doneStatus == 2'd0 ||
                     doneValid && frameIsData && doneStatus == 2'd1));

  // R9
  timeout_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doneValid && doneStatus == 2'd3) |-> !$past(rxValid));

  // R6
  done_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doneValid && doneStatus != 2'd3) |-> $past(rxValid));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |=> !doneValid);

  // R10
  done_no_pay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(doneValid && payValid));

endmodule

bind prog_frame_rx pfr_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .rxValid     (rxValid),
  .frameIsData (frameIsData),
  .cmdValid    (cmdValid),
  .payValid    (payValid),
  .doneValid   (doneValid),
  .doneStatus  (doneStatus),
  .moreFollows (moreFollows)
);

// File: tb/prog_frame_rx_tb_top.sv
module prog_frame_rx_tb_top;

  localparam int TO_W = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            rxValid = 1'b0;
  logic [7:0]      rxByte = 8'h00;
  logic [TO_W-1:0] timeoutCycles = 16'd40;
  logic            frameIsData, cmdValid, payValid, doneValid, moreFollows;
  logic [7:0]      cmdNum, payByte;
  logic [1:0]      doneStatus;

  always #5 clk = ~clk;

  prog_frame_rx #(.TO_W(TO_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .rxValid(rxValid), .rxByte(rxByte),
    .timeoutCycles(timeoutCycles), .frameIsData(frameIsData),
    .cmdValid(cmdValid), .cmdNum(cmdNum), .payValid(payValid),
    .payByte(payByte), .doneValid(doneValid), .doneStatus(doneStatus),
    .moreFollows(moreFollows)
  );

  // scoreboard queues
  logic [7:0] expPay[$];
  logic [7:0] expCmd[$];
  logic [3:0] expDone[$];   // {isData, more, status}

  int checks = 0, failures = 0;
  int monChecks = 0, monFails = 0;
  bit prevDone = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (payValid) begin
        monChecks++;
        if (expPay.size() == 0) begin
          monFails++;
          $display("FAIL R2/R8 unexpected payload actual=0x%0h expected=none", payByte);
        end else begin
          logic [7:0] e;
          e = expPay.pop_front();
          if (payByte !== e) begin
            monFails++;
            $display("FAIL R2 payload actual=0x%0h expected=0x%0h", payByte, e);
          end
        end
      end
      if (cmdValid) begin
        monChecks++;
        if (expCmd.size() == 0) begin
          monFails++;
          $display("FAIL R1/R8 unexpected command actual=0x%0h expected=none", cmdNum);
        end else begin
          logic [7:0] e;
          e = expCmd.pop_front();
          if (cmdNum !== e || frameIsData !== 1'b0) begin
            monFails++;
            $display("FAIL R1 command actual=0x%0h expected=0x%0h", cmdNum, e);
          end
        end
      end
      if (doneValid) begin
        monChecks++;
        if (prevDone) begin
          monFails++;
          $display("FAIL R10 done wide actual=1 expected=0");
        end
        if (expDone.size() == 0) begin
          monFails++;
          $display("FAIL R6/R8 unexpected done actual=0x%0h expected=none", doneStatus);
        end else begin
          logic [3:0] e;
          logic [3:0] a;
          e = expDone.pop_front();
          a = {frameIsData, moreFollows, doneStatus};
          if (a !== e) begin
            monFails++;
            $display("FAIL R4/R5/R6/R7/R9 done actual=0x%0h expected=0x%0h", a, e);
          end
        end
      end
      if (doneValid && payValid) begin
        monChecks++;
        monFails++;
        $display("FAIL R10 done with payload actual=1 expected=0");
      end
      prevDone = doneValid;
    end
  end

  task automatic sendByte(input logic [7:0] b);
    rxValid = 1'b1;
    rxByte  = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  // Builds, sends and predicts one packet. corruptAt: body index flipped
  // after the checksum is formed (-1 none). stopAfter: bytes sent (-1 all).
  task automatic runFrame(input bit isData, input logic [7:0] cmd,
                          input int nBody, input int corruptAt,
                          input bit badSum, input logic [7:0] trailer,
                          input int stopAfter, input logic [7:0] seed);
    logic [7:0] fr[0:263];
    logic [7:0] sum, lenByte, b;
    int idx, bodyStart, total, nSend;
    bit trailerOk;
    logic [1:0] st;
    sum       = 8'h00;
    lenByte   = isData ? 8'(nBody) : 8'(nBody + 1);
    fr[0]     = isData ? 8'h02 : 8'h01;
    fr[1]     = lenByte;
    sum       = sum - lenByte;
    idx       = 2;
    if (!isData) begin
      fr[2] = cmd;
      sum   = sum - cmd;
      idx   = 3;
    end
    bodyStart = idx;
    for (int i = 0; i < nBody; i++) begin
      b = seed + 8'(i * 7);
      fr[idx] = b;
      sum = sum - b;
      idx++;
    end
    if (corruptAt >= 0) fr[bodyStart + corruptAt] ^= 8'h10;
    fr[idx] = badSum ? (sum ^ 8'h5A) : sum;
    idx++;
    fr[idx] = trailer;
    total = idx + 1;
    nSend = (stopAfter < 0) ? total : stopAfter;

    for (int i = 0; i < nSend; i++) begin
      if (!isData && i == 2) expCmd.push_back(fr[i]);
      if (i >= bodyStart && i < bodyStart + nBody) expPay.push_back(fr[i]);
    end
    if (stopAfter >= 0) begin
      if (timeoutCycles != 0) expDone.push_back({isData, 1'b0, 2'd3});
    end else begin
      trailerOk = (trailer == 8'h03) || (isData && trailer == 8'h17);
      st = !trailerOk ? 2'd2 : ((badSum || corruptAt >= 0) ? 2'd1 : 2'd0);
      expDone.push_back({isData, isData && trailer == 8'h17, st});
    end

    for (int i = 0; i < nSend; i++) begin
      if (i % 3 == 2) @(negedge clk);
      sendByte(fr[i]);
    end

    if (stopAfter >= 0 && timeoutCycles != 0) begin
      // R9: pulse exactly timeoutCycles edges after the last byte
      repeat (int'(timeoutCycles) - 1) @(posedge clk);
      @(negedge clk);
      check(doneValid == 1'b0, "R9", "early timeout", doneValid, 0);
      @(posedge clk);
      @(negedge clk);
      check(doneValid == 1'b1 && doneStatus == 2'd3, "R9", "timeout pulse",
            {doneValid, doneStatus}, 3'b111);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + monChecks + 1,
             failures + monFails + 1);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 R10 reset state
    check(doneValid == 0 && payValid == 0 && cmdValid == 0 && moreFollows == 0,
          "R6", "reset outputs", {doneValid, payValid, cmdValid, moreFollows}, 0);

    // R1 R3: code only, then code with parameters
    runFrame(1'b0, 8'h20, 0, -1, 1'b0, 8'h03, -1, 8'h00);
    runFrame(1'b0, 8'h40, 5, -1, 1'b0, 8'h03, -1, 8'h31);
    // R2 R6: data closed with 0x03
    runFrame(1'b1, 8'h00, 16, -1, 1'b0, 8'h03, -1, 8'hA0);
    // R7: data closed with 0x17
    runFrame(1'b1, 8'h00, 8, -1, 1'b0, 8'h17, -1, 8'h11);
    // R3: length byte 0 means 256
    runFrame(1'b1, 8'h00, 256, -1, 1'b0, 8'h17, -1, 8'h05);
    // R4: corrupted parameter, corrupted checksum
    runFrame(1'b0, 8'h22, 4, 2, 1'b0, 8'h03, -1, 8'h77);
    runFrame(1'b1, 8'h00, 6, -1, 1'b1, 8'h03, -1, 8'h44);
    // R5: 0x17 on a command, bad closer plus bad checksum
    runFrame(1'b0, 8'h13, 2, -1, 1'b0, 8'h17, -1, 8'h09);
    runFrame(1'b1, 8'h00, 3, -1, 1'b1, 8'h42, -1, 8'h66);

    // R8: idle garbage is dropped, next packet parses normally
    sendByte(8'h55); sendByte(8'h03); sendByte(8'h17); sendByte(8'hFF);
    repeat (60) @(negedge clk);
    check(expDone.size() == 0 && expPay.size() == 0, "R8", "idle garbage",
          expDone.size() + expPay.size(), 0);
    runFrame(1'b1, 8'h00, 2, -1, 1'b0, 8'h03, -1, 8'h01);

    // R9: truncated data mid-body, truncated command before closer
    runFrame(1'b1, 8'h00, 10, -1, 1'b0, 8'h03, 5, 8'h20);
    runFrame(1'b0, 8'h32, 3, -1, 1'b0, 8'h03, 6, 8'h70);
    runFrame(1'b0, 8'hC0, 0, -1, 1'b0, 8'h03, -1, 8'h00);

    // R9: limit 0 disables, later nonzero limit still ends the packet
    timeoutCycles = 16'd0;
    runFrame(1'b1, 8'h00, 10, -1, 1'b0, 8'h03, 4, 8'h90);
    repeat (200) @(negedge clk);
    check(expDone.size() == 0, "R9", "disabled timeout", expDone.size(), 0);
    expDone.push_back({1'b1, 1'b0, 2'd3});
    timeoutCycles = 16'd40;
    repeat (50) @(negedge clk);
    check(expDone.size() == 0, "R9", "late limit fires", expDone.size(), 0);
    runFrame(1'b1, 8'h00, 4, -1, 1'b0, 8'h17, -1, 8'h3C);

    repeat (10) @(negedge clk);
    check(expPay.size() == 0, "R2", "payload drained", expPay.size(), 0);
    check(expCmd.size() == 0, "R1", "commands drained", expCmd.size(), 0);
    check(expDone.size() == 0, "R6", "results drained", expDone.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks + monChecks,
             failures + monFails);
    $finish;
  end

endmodule